// File: doc/BRIEF.md
# Address-Range Bus Watchpoint Unit

This block sits beside a memory arbiter and observes each granted transaction: its address, whether it reads or writes, which client issued it and how large it is. Software programs four independent watch windows. Each window carries an inclusive address range, a mask of the operation types it reacts to and a mask of the clients it reacts to. An access that satisfies all three filters of a window is a hit on that window.

On its first hit a window freezes the address, the operation, the size and the issuing client, so that software can later find out what tripped it. The set of clients that hit is gathered while the capture is held. Each hit also sets a sticky per-window status bit. A mask register decides which status bits reach the single interrupt line. Software rearms a window's capture by writing that window's acknowledge location. It clears status bits by writing ones to a clear location.

Register access uses a simple synchronous port: one write strobe, and a read address whose data is returned one clock later.

Top module: `bus_watch_unit`

## Requirements
- R1: After reset every configuration register, every capture, the status and mask registers and `irq_o` are zero. Because the operation masks are zero, no access can hit until software programs a window.
- R2: An access with `acc_valid` high hits window w only if all three hold: first ≤ `acc_addr` ≤ last, both bounds inclusive; the operation-mask bit selected by `acc_write` is set, where bit 0 means read and bit 1 means write; and bit `acc_client` of the client mask is set.
- R3: Register addresses. Window w occupies addresses w*8+k. For k=0 the location is the first address, k=1 the last address, k=2 the operation mask and k=3 the client mask, and all four read back what was written. k=4 reads the captured address and a write to it is the acknowledge. k=5 reads the captured client set, k=6 the capture info and k=7 the capture-valid flag in bit 0. Global registers: 32 is the interrupt mask, 33 the raw status (read only), 34 the masked status (read only) and 35 the write-one-to-clear location.
- R4: The first hit on a window whose capture is empty stores the address, the operation, the size and the client. Capture info is laid out as size in bits [7:5], write flag in bit 4 and first client in bits [3:0]. These values are held unchanged through any later hits until an acknowledge.
- R5: The captured client set is the one-hot of the first client. Each further hit ORs in its own client bit.
- R6: A write to a window's acknowledge location empties that window's capture. If a hit arrives in the same cycle, the acknowledge wins. The next hit after that captures afresh.
- R7: A hit sets the window's raw status bit whatever its mask bit is, and the bit stays set until it is cleared.
- R8: `irq_o` is high in the cycle after any status bit is set while its mask bit is 1. It is low in the cycle after no such bit exists.
- R9: A write to the clear location clears exactly the status bits written as 1. A hit in the same cycle keeps its bit set.
- R10: `rd_data` presents the register selected by `rd_addr` one clock after `rd_addr` was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Registered read data |
| acc_valid | input | 1 | Observed transaction is valid this cycle |
| acc_addr | input | 32 | Transaction address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_client | input | 4 | Issuing client index |
| acc_size | input | 3 | Transaction size code |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The matching logic is driven with a table of accesses against four windows that were chosen to differ along one axis each. One window spans a range and accepts both operations and all clients. One is a single address that accepts writes only. One accepts reads from one client only, and one covers all addresses for one client only. Accesses sit exactly on the bounds and one step outside them, use the wrong operation or a neighbouring client, and some land in two windows at once. This separates off-by-one range errors, a swapped operation-mask bit and a wrong client-bit index. Directed sequences then confirm that the capture freezes while the client set keeps gathering, that acknowledge rearms the capture, that masking gates the line without losing status, and that the clear location removes only the bits written as 1.

// File: rtl/bwatch_pkg.sv
package bwatch_pkg;

  // Per-window register index (low three address bits)
  typedef enum logic [2:0] {
    WR_FIRST   = 3'd0,
    WR_LAST    = 3'd1,
    WR_OPMASK  = 3'd2,
    WR_CLIMASK = 3'd3,
    WR_CAPADDR = 3'd4,  // write: acknowledge
    WR_CAPCLI  = 3'd5,
    WR_CAPINFO = 3'd6,
    WR_CAPVLD  = 3'd7
  } win_reg_e;

  // Global register index (low two address bits inside the global page)
  typedef enum logic [1:0] {
    GR_MASK  = 2'd0,
    GR_RAW   = 2'd1,
    GR_PEND  = 2'd2,
    GR_CLEAR = 2'd3
  } glb_reg_e;

  // Operation-mask bit positions
  localparam int OPB_READ  = 0;
  localparam int OPB_WRITE = 1;

endpackage

// File: rtl/bwatch_window.sv
module bwatch_window
  import bwatch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NCLI   = 16,
  parameter int CLI_W  = 4,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [CLI_W-1:0]  acc_client,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [2:0]        rd_idx,
  output logic [DATA_W-1:0] rd_val,
  output logic              hit_o,
  output logic              cap_valid_o,
  output logic [ADDR_W-1:0] cap_addr_o
);

  localparam int INFO_W = SIZE_W + 1 + CLI_W;

  logic [ADDR_W-1:0] first_q, last_q;
  logic [1:0]        opm_q;
  logic [NCLI-1:0]   clim_q;

  logic              capv_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [NCLI-1:0]   cap_cli_q;
  logic [INFO_W-1:0] cap_info_q;

  logic              ack;
  logic [NCLI-1:0]   cli_onehot;

  assign ack        = cfg_we && (win_reg_e'(cfg_idx) == WR_CAPADDR);
  assign cli_onehot = NCLI'(1) << acc_client;

  // Match: inclusive range, operation bit, client bit
  always_comb begin
    hit_o = acc_valid
         && (acc_addr >= first_q)
         && (acc_addr <= last_q)
         && opm_q[acc_write ? OPB_WRITE : OPB_READ]
         && clim_q[acc_client];
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      opm_q   <= '0;
      clim_q  <= '0;
    end else if (cfg_we) begin
      case (win_reg_e'(cfg_idx))
        WR_FIRST:   first_q <= cfg_data[ADDR_W-1:0];
        WR_LAST:    last_q  <= cfg_data[ADDR_W-1:0];
        WR_OPMASK:  opm_q   <= cfg_data[1:0];
        WR_CLIMASK: clim_q  <= cfg_data[NCLI-1:0];
        default: ;
      endcase
    end
  end

  // Capture: first hit freezes details, later hits gather clients
  always_ff @(posedge clk) begin
    if (rst) begin
      capv_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_cli_q  <= '0;
      cap_info_q <= '0;
    end else if (ack) begin
      capv_q    <= 1'b0;
      cap_cli_q <= '0;
    end else if (hit_o) begin
      if (!capv_q) begin
        capv_q     <= 1'b1;
        cap_addr_q <= acc_addr;
        cap_cli_q  <= cli_onehot;
        cap_info_q <= {acc_size, acc_write, acc_client};
      end else begin
        cap_cli_q <= cap_cli_q | cli_onehot;
      end
    end
  end

  always_comb begin
    case (win_reg_e'(rd_idx))
      WR_FIRST:   rd_val = DATA_W'(first_q);
      WR_LAST:    rd_val = DATA_W'(last_q);
      WR_OPMASK:  rd_val = DATA_W'(opm_q);
      WR_CLIMASK: rd_val = DATA_W'(clim_q);
      WR_CAPADDR: rd_val = DATA_W'(cap_addr_q);
      WR_CAPCLI:  rd_val = DATA_W'(cap_cli_q);
      WR_CAPINFO: rd_val = DATA_W'(cap_info_q);
      default:    rd_val = DATA_W'(capv_q);
    endcase
  end

  assign cap_valid_o = capv_q;
  assign cap_addr_o  = cap_addr_q;

endmodule

// File: rtl/bwatch_irq.sv
module bwatch_irq #(
  parameter int NWIN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NWIN-1:0] hit_vec,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_data,
  input  logic [NWIN-1:0] clr_vec,
  output logic [NWIN-1:0] status_o,
  output logic [NWIN-1:0] mask_o,
  output logic [NWIN-1:0] pend_o,
  output logic            irq_o
);

  logic [NWIN-1:0] st_q, msk_q;
  logic            irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= (st_q & ~clr_vec) | hit_vec;
      if (mask_we) msk_q <= mask_data;
      irq_q <= |(st_q & msk_q);
    end
  end

  assign status_o = st_q;
  assign mask_o   = msk_q;
  assign pend_o   = st_q & msk_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/bus_watch_unit.sv
module bus_watch_unit
  import bwatch_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 32,
  parameter int NCLI   = 16,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32,
  localparam int CLI_W  = $clog2(NCLI),
  localparam int WSEL_W = $clog2(NWIN),
  localparam int REG_AW = 1 + WSEL_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [CLI_W-1:0]  acc_client,
  input  logic [SIZE_W-1:0] acc_size,
  output logic              irq_o
);

  localparam int LOW_W = REG_AW - 1;

  logic [NWIN-1:0]   hit_vec, capv;
  logic [ADDR_W-1:0] caddr [NWIN];
  logic [DATA_W-1:0] win_rd [NWIN];
  logic [NWIN-1:0]   st, msk, pend, clr_vec;
  logic              wr_glb, rd_glb, mask_we;
  logic [DATA_W-1:0] rd_mux, rd_q;

  assign wr_glb  = wr_addr[REG_AW-1];
  assign rd_glb  = rd_addr[REG_AW-1];
  assign mask_we = wr_en && wr_glb
                && (wr_addr[LOW_W-1:0] == LOW_W'(GR_MASK));
  assign clr_vec = (wr_en && wr_glb && (wr_addr[LOW_W-1:0] == LOW_W'(GR_CLEAR)))
                 ? wr_data[NWIN-1:0] : '0;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic we_w;
    assign we_w = wr_en && !wr_glb && (wr_addr[3 +: WSEL_W] == WSEL_W'(w));

    bwatch_window #(
      .ADDR_W(ADDR_W), .NCLI(NCLI), .CLI_W(CLI_W),
      .SIZE_W(SIZE_W), .DATA_W(DATA_W)
    ) u_win (
      .clk        (clk),
      .rst        (rst),
      .cfg_we     (we_w),
      .cfg_idx    (wr_addr[2:0]),
      .cfg_data   (wr_data),
      .acc_valid  (acc_valid),
      .acc_addr   (acc_addr),
      .acc_write  (acc_write),
      .acc_client (acc_client),
      .acc_size   (acc_size),
      .rd_idx     (rd_addr[2:0]),
      .rd_val     (win_rd[w]),
      .hit_o      (hit_vec[w]),
      .cap_valid_o(capv[w]),
      .cap_addr_o (caddr[w])
    );
  end

  bwatch_irq #(.NWIN(NWIN)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .hit_vec  (hit_vec),
    .mask_we  (mask_we),
    .mask_data(wr_data[NWIN-1:0]),
    .clr_vec  (clr_vec),
    .status_o (st),
    .mask_o   (msk),
    .pend_o   (pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_glb) begin
      if (rd_addr[LOW_W-1:0] == LOW_W'(GR_MASK))      rd_mux = DATA_W'(msk);
      else if (rd_addr[LOW_W-1:0] == LOW_W'(GR_RAW))  rd_mux = DATA_W'(st);
      else if (rd_addr[LOW_W-1:0] == LOW_W'(GR_PEND)) rd_mux = DATA_W'(pend);
    end else begin
      rd_mux = win_rd[rd_addr[3 +: WSEL_W]];
    end
  end

  // R10: registered read data
  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/bwatch_chk.sv
module bwatch_chk #(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_o,
  input logic [NWIN-1:0]   st,
  input logic [NWIN-1:0]   msk,
  input logic [NWIN-1:0]   hit_vec,
  input logic [NWIN-1:0]   clr_vec,
  input logic [NWIN-1:0]   capv,
  input logic [ADDR_W-1:0] cap_addr0
);

  // R7: a hit leaves its status bit set next cycle
  a_r7_hit_sets: assert property (@(posedge clk) disable iff (rst)
    hit_vec[0] |=> st[0]);

  // R9: a status bit only falls after a clear request for it
  a_r9_only_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (st[0] && !hit_vec[0] && !clr_vec[0]) |=> st[0]);

  // R8: pending masked status raises the line next cycle
  a_r8_irq_on: assert property (@(posedge clk) disable iff (rst)
    (|(st & msk)) |=> irq_o);

  // R8: no pending masked status lowers the line next cycle
  a_r8_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(|(st & msk)) |=> !irq_o);

  // R4: the captured address is frozen while the capture stays valid
  a_r4_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (capv[0] && $past(capv[0])) |-> $stable(cap_addr0));

endmodule

bind bus_watch_unit bwatch_chk #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .st       (st),
  .msk      (msk),
  .hit_vec  (hit_vec),
  .clr_vec  (clr_vec),
  .capv     (capv),
  .cap_addr0(caddr[0])
);

// File: tb/sim_bus_watch_unit.sv
module sim_bus_watch_unit;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [3:0]  acc_client = '0;
  logic [2:0]  acc_size = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bus_watch_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_client(acc_client),
    .acc_size(acc_size), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic [3:0]  c;
    logic [3:0]  e;
  } vec_t;

  // address, write, client, expected raw status
  localparam vec_t VEC [13] = '{
    '{32'h0000_1000, 1'b0, 4'd0,  4'b0001},
    '{32'h0000_10FF, 1'b1, 4'd1,  4'b0001},
    '{32'h0000_0FFF, 1'b0, 4'd0,  4'b0000},
    '{32'h0000_1100, 1'b0, 4'd0,  4'b0000},
    '{32'h0000_1080, 1'b1, 4'd2,  4'b0011},
    '{32'h0000_1080, 1'b0, 4'd2,  4'b0001},
    '{32'h0000_2000, 1'b0, 4'd4,  4'b0100},
    '{32'h0000_2000, 1'b1, 4'd4,  4'b0000},
    '{32'h0000_2000, 1'b0, 4'd5,  4'b0000},
    '{32'h0000_1050, 1'b0, 4'd15, 4'b1001},
    '{32'h0000_2FFF, 1'b0, 4'd15, 4'b1000},
    '{32'h0000_3000, 1'b0, 4'd4,  4'b0000},
    '{32'h0000_1081, 1'b1, 4'd15, 4'b1001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R10: data valid one clock after the address
  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic acc(input logic [31:0] a, input logic w, input logic [3:0] c,
                     input logic [2:0] s);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_client = c; acc_size = s;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic logic [5:0] wa(input int w, input int k);
    return 6'(w * 8 + k);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", 32'(irq_o), 0);
    rd(6'd33, d); chk("R1 raw status", d, 0);
    rd(6'd32, d); chk("R1 mask", d, 0);
    rd(wa(0, 1), d); chk("R1 last addr", d, 0);
    rd(wa(2, 7), d); chk("R1 capture valid", d, 0);
    acc(32'h0, 1'b0, 4'd0, 3'd0);
    rd(6'd33, d); chk("R1 no hit unprogrammed", d, 0);

    // Program windows
    wr(wa(0,0), 32'h1000); wr(wa(0,1), 32'h10FF); wr(wa(0,2), 3); wr(wa(0,3), 32'hFFFF);
    wr(wa(1,0), 32'h1080); wr(wa(1,1), 32'h1080); wr(wa(1,2), 2); wr(wa(1,3), 32'hFFFF);
    wr(wa(2,0), 32'h2000); wr(wa(2,1), 32'h2FFF); wr(wa(2,2), 1); wr(wa(2,3), 32'h0010);
    wr(wa(3,0), 32'h0);    wr(wa(3,1), 32'hFFFF_FFFF); wr(wa(3,2), 3); wr(wa(3,3), 32'h8000);

    // R3: configuration readback
    rd(wa(2,3), d); chk("R3 client mask readback", d, 32'h10);
    rd(wa(1,2), d); chk("R3 op mask readback", d, 2);
    rd(wa(3,1), d); chk("R3 last addr readback", d, 32'hFFFF_FFFF);

    // R2/R7: table walk, mask zero, irq stays low
    for (int i = 0; i < 13; i++) begin
      acc(VEC[i].a, VEC[i].w, VEC[i].c, 3'(i));
      rd(6'd33, d);
      chk($sformatf("R2 vector %0d", i), d, 32'(VEC[i].e));
      chk("R7 masked irq low", 32'(irq_o), 0);
      wr(6'd35, 32'hF);
    end

    // R4/R5: capture held from first hit, clients gathered
    rd(wa(0,4), d); chk("R4 w0 captured addr", d, 32'h1000);
    rd(wa(0,6), d); chk("R4 w0 capture info", d, 32'h00);
    rd(wa(0,5), d); chk("R5 w0 client set", d, 32'h8007);
    rd(wa(1,6), d); chk("R4 w1 capture info", d, 32'h92);
    rd(wa(1,4), d); chk("R4 w1 captured addr", d, 32'h1080);

    // R6: acknowledge rearms capture
    wr(wa(0,4), 0);
    rd(wa(0,7), d); chk("R6 capture empty after ack", d, 0);
    rd(wa(0,5), d); chk("R6 client set cleared", d, 0);
    acc(32'h1010, 1'b1, 4'd3, 3'd1);
    rd(wa(0,4), d); chk("R6 recaptured addr", d, 32'h1010);
    rd(wa(0,6), d); chk("R6 recaptured info", d, 32'h33);
    rd(wa(1,7), d); chk("R6 other window untouched", d, 1);
    wr(6'd35, 32'hF);

    // R8: mask gating
    wr(6'd32, 32'h2);
    acc(32'h1010, 1'b0, 4'd0, 3'd0);
    @(negedge clk);
    chk("R8 unmasked window no irq", 32'(irq_o), 0);
    rd(6'd33, d); chk("R7 raw set while masked", d, 1);
    acc(32'h1080, 1'b1, 4'd0, 3'd0);
    @(negedge clk);
    chk("R8 irq raised", 32'(irq_o), 1);
    rd(6'd34, d); chk("R8 masked status", d, 2);

    // R9: partial clear
    wr(6'd35, 32'h2);
    @(negedge clk);
    chk("R9 irq dropped", 32'(irq_o), 0);
    rd(6'd33, d); chk("R9 untouched bit kept", d, 1);
    wr(6'd35, 32'h1);
    rd(6'd33, d); chk("R9 all clear", d, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule